// File: doc/BRIEF.md
# Sense-Reversing Hardware Barrier

This block synchronises a fixed group of N participants. A participant signals that it has reached the synchronisation point with a one-cycle pulse on its bit of `arrive_i`, then holds until its bit of `go_o` pulses. Once every participant has arrived, all of them are released together. The unit can then be used again for the next episode straight away.

Each participant has a local sense bit, and the unit has one shared release bit. An arrival flips the participant's sense. A participant is blocked while its sense differs from the release bit. When the arrival count reaches N, the count returns to zero and the release bit flips to the value that every participant's sense now holds. The release of one episode therefore also resets the next one. A participant that comes back early only flips its own sense, so it cannot hold up a slower participant that has not yet left.

The count is either one flat counter (`TOPO = TOPO_FLAT`) or a binary combining tree of two-input counters (`TOPO = TOPO_TREE`). In the tree, one pipeline register separates adjacent levels. Tree mode needs N to be a power of two and at least 4.

Top module: `sync_barrier`

## Requirements
- R1: After reset, `go_o` is all zeros. Every local sense bit and the release bit reset to 1, so no participant is blocked, and the first complete set of arrivals is accepted.
- R2: An accepted arrival flips that participant's local sense bit. The participant then stays blocked until the next release.
- R3: All arrival pulses accepted in the same cycle are counted: the count grows by the number of accepted pulses, and arrivals spread over any pattern of cycles add up to one episode.
- R4: In flat mode, the cycle in which the N-th arrival is sampled ends the episode. At that clock edge the count returns to 0, the release bit takes the new sense value, and `go_o` goes to all ones for the cycle that follows.
- R5: An arrival pulse from a participant that is blocked in the current episode is ignored. It does not add to the count.
- R6: A participant may arrive again in the same cycle its `go_o` is high, or in any later cycle. Such early re-entry never stops the next episode from completing once all N participants have arrived for it.
- R7: In tree mode, participants are paired into two-input nodes over log2(N) levels, with one register between levels. `go_o` rises log2(N)-1 cycles later than in flat mode. Arrivals made between the completion of the root node and `go_o` are ignored.
- R8: For each completed episode, `go_o` is high for exactly one cycle. Back-to-back episodes in flat mode give one pulse per episode on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| arrive_i | input | N | One-cycle arrival pulse, one bit per participant |
| go_o | output | N | One-cycle release pulse, one bit per participant |

## Verification
The bench builds two instances side by side. The flat instance uses N = 5, so the participant count is not a power of two and the counter has to cover an uneven total. The tree instance uses N = 8, which gives three levels of pairwise nodes and a two-cycle extra release delay. With that delay, the bench can drive arrivals into the window where the root has completed but `go_o` has not yet risen. Both instances get simultaneous, staggered, repeated and early re-entry arrivals, so ignored pulses and deadlock-free reuse show up in the timing of `go_o`.

// File: rtl/sync_barrier_pkg.sv
package sync_barrier_pkg;

  // How the arrival count is built.
  typedef enum logic {
    TOPO_FLAT = 1'b0,  // one N-input counter, release on the completing edge
    TOPO_TREE = 1'b1   // pairwise counters, one register per level
  } topo_e;

endpackage

// File: rtl/sync_barrier_count.sv
// W-input arrival counter. done_o is high in the cycle that completes W arrivals.
module sync_barrier_count #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] arrive_i,
  output logic         done_o
);

  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic [CW-1:0] pop;
  logic [CW-1:0] sum;
  logic          cnt_en;

  always_comb begin
    pop = '0;
    for (int i = 0; i < W; i++) begin
      pop = pop + CW'(arrive_i[i]);
    end
    sum    = cnt_q + pop;
    done_o = (sum == CW'(W));
    cnt_d  = done_o ? '0 : sum;
    cnt_en = |arrive_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt_q < CW'(W)); // R3
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> cnt_q == '0); // R4

endmodule

// File: rtl/sync_barrier_tree.sv
// Combining tree of two-input counters in heap order.
// sig[0..N-1] holds the participant arrivals. Node j reads sig[2j+1:2j].
// Every node except the root feeds its registered done into sig[N+j].
module sync_barrier_tree #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] arrive_i,
  output logic         done_o
);

  localparam int NODES = N - 1;
  localparam int PIPES = N - 2;

  logic [NODES-1:0]   node_done;
  logic [PIPES-1:0]   pipe_q;
  logic [PIPES-1:0]   pipe_d;
  logic [2*N-3:0]     sig;

  assign sig = {pipe_q, arrive_i};

  for (genvar j = 0; j < NODES; j++) begin : g_node
    sync_barrier_count #(.W(2)) u_pair (
      .clk      (clk),
      .rst_n    (rst_n),
      .arrive_i (sig[2*j+1:2*j]),
      .done_o   (node_done[j])
    );
  end

  always_comb begin
    pipe_d = node_done[PIPES-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign done_o = node_done[NODES-1];

  // An episode lasts at least as many cycles as there are levels, so no
  // inner node can complete on two cycles in a row.
  AST_TREE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) (pipe_q & $past(pipe_q)) == '0); // R7

endmodule

// File: rtl/sync_barrier.sv
module sync_barrier
  import sync_barrier_pkg::*;
#(
  parameter int    N    = 4,
  parameter topo_e TOPO = TOPO_FLAT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] arrive_i,
  output logic [N-1:0] go_o
);

  logic [N-1:0] sense_q;
  logic [N-1:0] sense_d;
  logic         sense_en;
  logic         release_q;
  logic         release_d;
  logic         release_en;
  logic [N-1:0] go_q;
  logic [N-1:0] go_d;
  logic [N-1:0] waiting;
  logic [N-1:0] accept;
  logic         done_w;

  // A participant is blocked while its sense differs from the release bit.
  assign waiting = sense_q ^ {N{release_q}};
  assign accept  = arrive_i & ~waiting;

  if (TOPO == TOPO_TREE) begin : g_tree
    sync_barrier_tree #(.N(N)) u_tree (
      .clk      (clk),
      .rst_n    (rst_n),
      .arrive_i (accept),
      .done_o   (done_w)
    );
  end else begin : g_flat
    sync_barrier_count #(.W(N)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .arrive_i (accept),
      .done_o   (done_w)
    );
  end

  always_comb begin
    sense_d    = sense_q ^ accept;
    sense_en   = |accept;
    release_d  = ~release_q;
    release_en = done_w;
    go_d       = {N{done_w}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '1;
    end else if (sense_en) begin
      sense_q <= sense_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      release_q <= 1'b1;
    end else if (release_en) begin
      release_q <= release_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q <= '0;
    end else begin
      go_q <= go_d;
    end
  end

  assign go_o = go_q;

  AST_DONE_FULL:   assert property (@(posedge clk) disable iff (!rst_n) done_w |-> &(waiting | accept)); // R3
  AST_GO_FREES:    assert property (@(posedge clk) disable iff (!rst_n) (|go_q) |-> (sense_q == {N{release_q}})); // R4
  AST_RELEASE_GO:  assert property (@(posedge clk) disable iff (!rst_n) (release_q != $past(release_q)) |-> &go_q); // R4
  AST_WAIT_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) !done_w |=> ((sense_q ^ $past(sense_q)) & $past(waiting)) == '0); // R5

endmodule

// File: tb/sync_barrier_tb.sv
`timescale 1ns/1ps
module sync_barrier_tb_top;
  import sync_barrier_pkg::*;

  localparam int NF = 5;
  localparam int NT = 8;
  localparam int TL = $clog2(NT);

  typedef struct {
    int    cyc;
    string tag;
  } exp_t;

  logic          clk;
  logic          rst_n;
  logic [NF-1:0] arr_f;
  logic [NT-1:0] arr_t;
  logic [NF-1:0] go_f;
  logic [NT-1:0] go_t;

  exp_t          qf[$];
  exp_t          qt[$];
  int            cyc;
  int            checks;
  int            errs;
  logic [NF-1:0] pf;
  logic [NT-1:0] pt;
  int            free_f;
  int            free_t;
  bit            finished;

  sync_barrier #(.N(NF), .TOPO(TOPO_FLAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .arrive_i(arr_f), .go_o(go_f)
  );

  sync_barrier #(.N(NT), .TOPO(TOPO_TREE)) dut_tree_i (
    .clk(clk), .rst_n(rst_n), .arrive_i(arr_t), .go_o(go_t)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Driver: applies one cycle of arrivals and pushes the expected releases.
  task automatic step(input logic [NF-1:0] mf, input logic [NT-1:0] mt, input string tag);
    logic [NF-1:0] af;
    logic [NT-1:0] at;
    arr_f = mf;
    arr_t = mt;
    af = (cyc >= free_f) ? (mf & ~pf) : '0;
    at = (cyc >= free_t) ? (mt & ~pt) : '0;
    pf = pf | af;
    pt = pt | at;
    if (pf == '1) begin
      qf.push_back('{cyc + 1, tag});
      pf = '0;
      free_f = cyc + 1;
    end
    if (pt == '1) begin
      qt.push_back('{cyc + TL, tag});
      pt = '0;
      free_t = cyc + TL;
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step('0, '0, "");
  endtask

  // Monitor: pops the scoreboard as releases appear.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (qf.size() > 0 && qf[0].cyc == cyc) begin
        checks++;
        if (go_f !== '1) begin
          errs++;
          $display("FAIL %s flat: go at cycle %0d actual=%b expected=%b", qf[0].tag, cyc, go_f, {NF{1'b1}});
        end
        void'(qf.pop_front());
      end else if (go_f !== '0) begin
        checks++;
        errs++;
        $display("FAIL R8 flat: unexpected go at cycle %0d actual=%b expected=%b", cyc, go_f, {NF{1'b0}});
      end
      if (qf.size() > 0 && qf[0].cyc < cyc) begin
        checks++;
        errs++;
        $display("FAIL %s flat: go missing for cycle %0d actual=0 expected=1", qf[0].tag, qf[0].cyc);
        void'(qf.pop_front());
      end
      if (qt.size() > 0 && qt[0].cyc == cyc) begin
        checks++;
        if (go_t !== '1) begin
          errs++;
          $display("FAIL %s tree: go at cycle %0d actual=%b expected=%b", qt[0].tag, cyc, go_t, {NT{1'b1}});
        end
        void'(qt.pop_front());
      end else if (go_t !== '0) begin
        checks++;
        errs++;
        $display("FAIL R8 tree: unexpected go at cycle %0d actual=%b expected=%b", cyc, go_t, {NT{1'b0}});
      end
      if (qt.size() > 0 && qt[0].cyc < cyc) begin
        checks++;
        errs++;
        $display("FAIL %s tree: go missing for cycle %0d actual=0 expected=1", qt[0].tag, qt[0].cyc);
        void'(qt.pop_front());
      end
    end
  end

  initial begin
    #200us;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errs++;
      $display("FAIL watchdog: run hung actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    checks = 0; errs = 0; finished = 1'b0;
    pf = '0; pt = '0; free_f = 0; free_t = 0;
    arr_f = '0; arr_t = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet while in reset
    checks++;
    if (go_f !== '0 || go_t !== '0) begin
      errs++;
      $display("FAIL R1: go in reset actual=%b/%b expected=0/0", go_f, go_t);
    end
    rst_n = 1'b1;
    idle(2);

    // R1 R3: first episode, all arrive in one cycle
    step('1, '1, "R1_R3");
    idle(4);

    // R4 R2: staggered arrivals, one participant group per cycle
    step(5'b00001, 8'h01, "R4");
    step(5'b00010, 8'h02, "R4");
    step(5'b00100, 8'h0C, "R4");
    step(5'b01000, 8'h30, "R4");
    step(5'b10000, 8'hC0, "R4");
    idle(4);

    // R5: repeated pulses from a blocked participant are not counted
    step(5'b00001, 8'h01, "R5");
    step(5'b00001, 8'h01, "R5");
    step(5'b00001, 8'h01, "R5");
    step(5'b01110, 8'h7E, "R5");
    idle(4);
    step(5'b10000, 8'h80, "R5");
    idle(4);

    // R7: arrivals inside the tree's release delay are ignored
    step('0, 8'hFF, "R7");
    step('0, 8'h01, "R7");
    step('0, 8'h02, "R7");
    idle(3);
    step('0, 8'hFF, "R7");
    idle(4);

    // R6: fast participant re-enters in the go cycle (flat)
    step(5'b01111, '0, "R6");
    step(5'b10000, '0, "R6");
    step(5'b00001, '0, "R6");
    idle(2);
    step(5'b11110, '0, "R6");
    idle(3);

    // R8: back-to-back flat episodes on consecutive cycles
    step('1, '0, "R8");
    step('1, '0, "R8");
    step('1, '0, "R8");
    idle(4);

    // R6: fast re-entry at the tree release cycle
    step('0, 8'hFF, "R6");
    idle(TL - 1);
    step('0, 8'h01, "R6");
    step('0, 8'hFE, "R6");
    idle(5);

    // R3: interleaved simultaneous arrivals across tree pairs
    step(5'b10101, 8'h5A, "R3");
    step(5'b01010, 8'hA5, "R3");
    idle(8);

    // R4: nothing left outstanding
    checks++;
    if (qf.size() != 0 || qt.size() != 0) begin
      errs++;
      $display("FAIL R4: pending releases actual=%0d/%0d expected=0/0", qf.size(), qt.size());
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule